// File: doc/BRIEF.md
# I2C Register Bridge

This block sits between an I2C target byte engine and a local 32-bit register bus. The byte engine reports each bus event as a one-cycle strobe: start of a write transfer, start of a read transfer, a written byte, a request for a read byte, or stop. The bridge answers every event with a one-cycle `ev_done` pulse. The pulse carries the NAK flag for written bytes and the returned byte for read requests. The first byte of each write transfer selects a register through a fixed index map. Bytes aimed at the data FIFO go straight to the register bus. Bytes for other registers collect in a five-entry buffer (the index plus four data bytes) and are sent as one word when stop arrives. Two registers are held inside the bridge and never appear on the register bus: locality select and checksum enable.

The register-bus address is the mapped offset plus the current locality shifted left by `LOC_SHIFT`. A register-bus access holds `bus_req` until `bus_done` arrives, and the bridge takes no new event while it waits. The control path has two states. `ST_IDLE` accepts events. `ST_WAIT` holds a register-bus access. The transition IDLE→WAIT happens when an event needs the bus (FIFO byte write, FIFO byte read, first fetch of a bus-backed register, or commit at stop). The transition WAIT→IDLE happens on `bus_done`. Every other event is handled in IDLE in a single cycle. The transfer itself is tracked as an operation: NONE, SEND once an accepted byte has been written, and RECV after the first read request.

Top module: `i2c_reg_bridge`

## Requirements
- R1: Index map (I2C index → bus offset): 0x00 locality select (local), 0x04→0x000, 0x08 interrupt enable→0x008, 0x14 interrupt capability (local), 0x18..0x1B status→0x018, 0x24 data FIFO→0x024, 0x30→0x014, 0x40 checksum enable (local), 0x44→0x080, 0x48→0xF00, 0x4C→0xF04. A first written byte that is not in this map is NAKed (`ev_nak`=1). So is 0x38, the device-address register. Any mapped index is ACKed.
- R2: Within one write transfer, the index and up to four data bytes are ACKed. A further non-FIFO byte is NAKed.
- R3: Each data byte written after index 0x24 is forwarded at once as a 1-byte bus write at offset 0x024, carrying the byte in `bus_wdata[7:0]`. There is no limit on the number of such bytes.
- R4: Data bytes for any other bus-backed register cause no bus access until stop. At stop, if at least one data byte was written, a 4-byte bus write is issued. Its data is little-endian: the first data byte is in bits 7:0, and bytes not sent are zero.
- R5: A write to locality select stores the value only if it is below `NUM_LOC`, and it causes no bus access. Reading it returns the stored value. Every bus address equals the offset plus locality<<`LOC_SHIFT`.
- R6: A write to checksum enable keeps only bit 0 of the first data byte and causes no bus access. Reading it returns that bit.
- R7: A status write at index 0x18 is a 4-byte write at 0x018. A status write at 0x18+k (k = 1..3) is a 1-byte write at 0x018+k. In both cases the data is the assembled word ANDed with `STS_WMASK>>(8k)`.
- R8: The first read request after an index write fetches one 32-bit value and returns its byte 0. The next three requests return bytes 1..3 from the cache with no bus access. Requests after that return 0.
- R9: A status read at 0x18+k clears bits 31:26 of the fetched value and then shifts it right by 8k.
- R10: A read of interrupt capability returns `INT_MASK`, and a write to it is dropped with no bus access.
- R11: Every read request on the data FIFO issues its own 1-byte bus read and returns `bus_rdata[7:0]`.
- R12: A write to interrupt enable is ANDed with `INT_MASK` before it reaches the bus.
- R13: The following all clear the buffer and the operation: start of write, stop when the operation is not SEND, stop after a committed write, and reset. After that, read requests return 0. Reset also sets the locality to 0 and checksum enable to 0, and leaves `ev_ready`=1, `bus_req`=0 and `ev_done`=0.
- R14: `bus_req` and its address, data and direction stay unchanged until `bus_done`. `ev_ready` is low while a bus access is pending. `ev_done` pulses only one cycle after an accepted event or after a `bus_done`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low reset |
| ev_valid | input | 1 | Event strobe, taken when `ev_ready` is high |
| ev_kind | input | 3 | 0 start-write, 1 start-read, 2 write byte, 3 read byte, 4 stop |
| ev_wdata | input | 8 | Byte for a write-byte event |
| ev_ready | output | 1 | Bridge can take an event |
| ev_done | output | 1 | One-cycle completion pulse |
| ev_nak | output | 1 | NAK reply, valid with `ev_done` |
| ev_rdata | output | 8 | Read byte, valid with `ev_done` |
| bus_req | output | 1 | Register-bus request, held until done |
| bus_we | output | 1 | 1 write, 0 read |
| bus_addr | output | ADDR_W | Register-bus byte address |
| bus_wdata | output | 32 | Write data |
| bus_size | output | 3 | Access size in bytes (1 or 4) |
| bus_rdata | input | 32 | Read data, valid with `bus_done` |
| bus_done | input | 1 | Access complete |

## Verification
Most faults show up on the register bus within one event. A wrong byte counter or operation state either produces a bus write at stop that should not happen, or drops one that should, and this is visible the cycle after the stop strobe. A stale read cache shows on the very next read request: a bad byte is returned, or an unexpected extra bus read is counted. A corrupted locality does not show when it is written. It shows in the address bits above `LOC_SHIFT` on the next bus access.

// File: rtl/i2cb_pkg.sv
package i2cb_pkg;

    typedef enum logic [2:0] {
        EV_START_WR = 3'd0,
        EV_START_RD = 3'd1,
        EV_WR_BYTE  = 3'd2,
        EV_RD_BYTE  = 3'd3,
        EV_STOP     = 3'd4
    } ev_kind_e;

    typedef enum logic [1:0] {OP_NONE, OP_SEND, OP_RECV} op_e;

    typedef enum logic [2:0] {
        RK_BUS, RK_FIFO, RK_STS, RK_INTEN, RK_LOC, RK_CSUM, RK_INTCAP
    } reg_kind_e;

    localparam logic [7:0] IX_LOC     = 8'h00;
    localparam logic [7:0] IX_ACCESS  = 8'h04;
    localparam logic [7:0] IX_INTEN   = 8'h08;
    localparam logic [7:0] IX_INTCAP  = 8'h14;
    localparam logic [7:0] IX_STS     = 8'h18;
    localparam logic [7:0] IX_FIFO    = 8'h24;
    localparam logic [7:0] IX_IFCAP   = 8'h30;
    localparam logic [7:0] IX_CSUMEN  = 8'h40;
    localparam logic [7:0] IX_CSUMGET = 8'h44;
    localparam logic [7:0] IX_DEVID   = 8'h48;
    localparam logic [7:0] IX_REV     = 8'h4C;

    localparam logic [11:0] OFF_STS  = 12'h018;
    localparam logic [11:0] OFF_FIFO = 12'h024;

    typedef struct packed {
        logic        hit;
        reg_kind_e   kind;
        logic [11:0] offset;
        logic [1:0]  sub;
    } reg_map_t;

endpackage

// File: rtl/i2cb_decode.sv
module i2cb_decode
    import i2cb_pkg::*;
#(
    parameter logic [11:0] CSUM_GET_OFF = 12'h080
) (
    input  logic [7:0] idx,
    output reg_map_t   map
);
    always_comb begin
        map = '{hit: 1'b1, kind: RK_BUS, offset: 12'h000, sub: 2'd0};
        if (idx[7:2] == IX_STS[7:2]) begin
            map.kind   = RK_STS;
            map.offset = OFF_STS;
            map.sub    = idx[1:0];
        end else begin
            unique case (idx)
                IX_LOC:     map.kind = RK_LOC;
                IX_ACCESS:  map.offset = 12'h000;
                IX_INTEN:   begin map.kind = RK_INTEN; map.offset = 12'h008; end
                IX_INTCAP:  map.kind = RK_INTCAP;
                IX_FIFO:    begin map.kind = RK_FIFO; map.offset = OFF_FIFO; end
                IX_IFCAP:   map.offset = 12'h014;
                IX_CSUMEN:  map.kind = RK_CSUM;
                IX_CSUMGET: map.offset = CSUM_GET_OFF;
                IX_DEVID:   map.offset = 12'hF00;
                IX_REV:     map.offset = 12'hF04;
                default:    map.hit = 1'b0;
            endcase
        end
    end
endmodule

// File: rtl/i2cb_bus_port.sv
module i2cb_bus_port #(
    parameter int ADDR_W = 16
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              launch,
    input  logic              l_we,
    input  logic [ADDR_W-1:0] l_addr,
    input  logic [31:0]       l_wdata,
    input  logic [2:0]        l_size,
    input  logic              bus_done,
    output logic              bus_req,
    output logic              bus_we,
    output logic [ADDR_W-1:0] bus_addr,
    output logic [31:0]       bus_wdata,
    output logic [2:0]        bus_size
);
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            bus_req   <= 1'b0;
            bus_we    <= 1'b0;
            bus_addr  <= '0;
            bus_wdata <= '0;
            bus_size  <= 3'd0;
        end else if (launch) begin
            bus_req   <= 1'b1;
            bus_we    <= l_we;
            bus_addr  <= l_addr;
            bus_wdata <= l_wdata;
            bus_size  <= l_size;
        end else if (bus_done) begin
            bus_req   <= 1'b0;
        end
    end
endmodule

// File: rtl/i2c_reg_bridge.sv
module i2c_reg_bridge
    import i2cb_pkg::*;
#(
    parameter int          ADDR_W       = 16,
    parameter int          LOC_SHIFT    = 12,
    parameter int          NUM_LOC      = 5,
    parameter logic [31:0] STS_WMASK    = 32'h0C00_00EE,
    parameter logic [31:0] INT_MASK     = 32'h8000_0087,
    parameter logic [11:0] CSUM_GET_OFF = 12'h080
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              ev_valid,
    input  logic [2:0]        ev_kind,
    input  logic [7:0]        ev_wdata,
    output logic              ev_ready,
    output logic              ev_done,
    output logic              ev_nak,
    output logic [7:0]        ev_rdata,
    output logic              bus_req,
    output logic              bus_we,
    output logic [ADDR_W-1:0] bus_addr,
    output logic [31:0]       bus_wdata,
    output logic [2:0]        bus_size,
    input  logic [31:0]       bus_rdata,
    input  logic              bus_done
);
    localparam int          LOC_W     = (NUM_LOC > 1) ? $clog2(NUM_LOC) : 1;
    localparam int          BUF_N     = 5;
    localparam int          CNT_W     = $clog2(BUF_N + 1);
    localparam logic [31:0] STS_RMASK = 32'h03FF_FFFF;

    typedef enum logic {ST_IDLE, ST_WAIT} state_e;
    typedef enum logic [1:0] {PD_FIFO_WR, PD_COMMIT, PD_FETCH, PD_FIFO_RD} pend_e;

    state_e            state_q, state_d;
    op_e               op_q, op_d;
    pend_e             pend_q, pend_d;
    logic [CNT_W-1:0]  cnt_q, cnt_d;
    logic [7:0]        buf_q [BUF_N];
    logic [7:0]        buf_d [BUF_N];
    logic [LOC_W-1:0]  loc_q, loc_d;
    logic              csum_q, csum_d;
    logic              done_q, done_d, nak_q, nak_d;
    logic [7:0]        rdata_q, rdata_d;
    logic              clear_txn, load_fetch;

    logic              launch, l_we;
    logic [ADDR_W-1:0] l_addr, base_addr, cm_addr;
    logic [31:0]       l_wdata, cm_wdata, wr_word, fetch_word;
    logic [2:0]        l_size, cm_size;
    logic [4:0]        sub_sh;
    logic [7:0]        dec_idx;
    reg_map_t          dm;
    ev_kind_e          kind;

    assign kind    = ev_kind_e'(ev_kind);
    assign dec_idx = (state_q == ST_IDLE && kind == EV_WR_BYTE && cnt_q == '0)
                     ? ev_wdata : buf_q[0];

    i2cb_decode #(.CSUM_GET_OFF(CSUM_GET_OFF)) u_dec (.idx(dec_idx), .map(dm));

    assign base_addr = ADDR_W'(dm.offset) + (ADDR_W'(loc_q) << LOC_SHIFT);
    assign wr_word   = {buf_q[4], buf_q[3], buf_q[2], buf_q[1]};
    assign sub_sh    = {dm.sub, 3'b000};

    // Commit word for a buffered write at stop
    always_comb begin
        cm_addr  = base_addr;
        cm_size  = 3'd4;
        cm_wdata = wr_word;
        unique case (dm.kind)
            RK_STS: begin
                cm_addr  = base_addr + ADDR_W'(dm.sub);
                cm_size  = (dm.sub == 2'd0) ? 3'd4 : 3'd1;
                cm_wdata = wr_word & (STS_WMASK >> sub_sh);
            end
            RK_INTEN: cm_wdata = wr_word & INT_MASK;
            default:  cm_wdata = wr_word;
        endcase
    end

    // Value cached on the first read of a register
    always_comb begin
        unique case (dm.kind)
            RK_LOC:    fetch_word = 32'(loc_q);
            RK_CSUM:   fetch_word = {31'b0, csum_q};
            RK_INTCAP: fetch_word = INT_MASK;
            RK_FIFO:   fetch_word = {24'b0, bus_rdata[7:0]};
            RK_STS:    fetch_word = (bus_rdata & STS_RMASK) >> sub_sh;
            default:   fetch_word = bus_rdata;
        endcase
    end

    // Next-state and output logic
    always_comb begin
        state_d = state_q; op_d = op_q; pend_d = pend_q; cnt_d = cnt_q;
        buf_d = buf_q; loc_d = loc_q; csum_d = csum_q;
        done_d = 1'b0; nak_d = nak_q; rdata_d = rdata_q;
        clear_txn = 1'b0; load_fetch = 1'b0;
        launch = 1'b0; l_we = 1'b0; l_addr = base_addr; l_wdata = '0; l_size = 3'd4;
        unique case (state_q)
            ST_IDLE: if (ev_valid) begin
                nak_d = 1'b0;
                unique case (kind)
                    EV_START_WR: begin clear_txn = 1'b1; done_d = 1'b1; end
                    EV_WR_BYTE: begin
                        if ((cnt_q == '0 && !dm.hit) || cnt_q >= CNT_W'(BUF_N)) begin
                            nak_d = 1'b1; done_d = 1'b1;
                        end else begin
                            op_d = OP_SEND;
                            if (cnt_q != '0 && dm.kind == RK_FIFO) begin
                                launch = 1'b1; l_we = 1'b1; l_size = 3'd1;
                                l_wdata = {24'b0, ev_wdata};
                                pend_d = PD_FIFO_WR; state_d = ST_WAIT;
                            end else begin
                                buf_d[cnt_q] = ev_wdata;
                                cnt_d = cnt_q + 1'b1; done_d = 1'b1;
                            end
                        end
                    end
                    EV_RD_BYTE: begin
                        if (op_q == OP_RECV) begin
                            if (dm.kind == RK_FIFO) begin
                                launch = 1'b1; l_size = 3'd1;
                                pend_d = PD_FIFO_RD; state_d = ST_WAIT;
                            end else begin
                                rdata_d = (cnt_q < CNT_W'(BUF_N)) ? buf_q[cnt_q] : 8'h00;
                                if (cnt_q < CNT_W'(BUF_N)) cnt_d = cnt_q + 1'b1;
                                done_d = 1'b1;
                            end
                        end else if (op_q == OP_SEND && cnt_q < CNT_W'(2)) begin
                            op_d = OP_RECV;
                            if (dm.kind == RK_LOC || dm.kind == RK_CSUM || dm.kind == RK_INTCAP) begin
                                load_fetch = 1'b1; done_d = 1'b1;
                            end else begin
                                launch = 1'b1;
                                l_size = (dm.kind == RK_FIFO) ? 3'd1 : 3'd4;
                                pend_d = PD_FETCH; state_d = ST_WAIT;
                            end
                        end else begin
                            op_d = OP_RECV; rdata_d = 8'h00; done_d = 1'b1;
                        end
                    end
                    EV_STOP: begin
                        if (op_q != OP_SEND) begin
                            clear_txn = 1'b1; done_d = 1'b1;
                        end else if (cnt_q > CNT_W'(1)) begin
                            unique case (dm.kind)
                                RK_CSUM: begin csum_d = buf_q[1][0]; clear_txn = 1'b1; done_d = 1'b1; end
                                RK_LOC: begin
                                    if (buf_q[1] < 8'(NUM_LOC)) loc_d = LOC_W'(buf_q[1]);
                                    clear_txn = 1'b1; done_d = 1'b1;
                                end
                                RK_FIFO, RK_INTCAP: begin clear_txn = 1'b1; done_d = 1'b1; end
                                default: begin
                                    launch = 1'b1; l_we = 1'b1; l_addr = cm_addr;
                                    l_wdata = cm_wdata; l_size = cm_size;
                                    pend_d = PD_COMMIT; state_d = ST_WAIT;
                                end
                            endcase
                        end else begin
                            done_d = 1'b1;
                        end
                    end
                    default: done_d = 1'b1;
                endcase
            end
            ST_WAIT: if (bus_done) begin
                state_d = ST_IDLE; done_d = 1'b1;
                unique case (pend_q)
                    PD_COMMIT:  clear_txn = 1'b1;
                    PD_FETCH:   load_fetch = 1'b1;
                    PD_FIFO_RD: rdata_d = bus_rdata[7:0];
                    default:    nak_d = 1'b0;
                endcase
            end
            default: state_d = ST_IDLE;
        endcase
        if (load_fetch) begin
            for (int i = 1; i < BUF_N; i++) buf_d[i] = fetch_word[8*(i-1) +: 8];
            rdata_d = fetch_word[7:0];
            cnt_d   = CNT_W'(2);
        end
        if (clear_txn) begin
            op_d  = OP_NONE;
            cnt_d = '0;
            for (int i = 0; i < BUF_N; i++) buf_d[i] = 8'h00;
        end
    end

    // State register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= ST_IDLE; op_q <= OP_NONE; pend_q <= PD_FIFO_WR;
            cnt_q <= '0; loc_q <= '0; csum_q <= 1'b0;
            done_q <= 1'b0; nak_q <= 1'b0; rdata_q <= 8'h00;
            for (int i = 0; i < BUF_N; i++) buf_q[i] <= 8'h00;
        end else begin
            state_q <= state_d; op_q <= op_d; pend_q <= pend_d;
            cnt_q <= cnt_d; loc_q <= loc_d; csum_q <= csum_d;
            done_q <= done_d; nak_q <= nak_d; rdata_q <= rdata_d;
            for (int i = 0; i < BUF_N; i++) buf_q[i] <= buf_d[i];
        end
    end

    i2cb_bus_port #(.ADDR_W(ADDR_W)) u_port (
        .clk(clk), .rst_n(rst_n), .launch(launch), .l_we(l_we), .l_addr(l_addr),
        .l_wdata(l_wdata), .l_size(l_size), .bus_done(bus_done),
        .bus_req(bus_req), .bus_we(bus_we), .bus_addr(bus_addr),
        .bus_wdata(bus_wdata), .bus_size(bus_size)
    );

    assign ev_ready = (state_q == ST_IDLE);
    assign ev_done  = done_q;
    assign ev_nak   = nak_q;
    assign ev_rdata = rdata_q;

endmodule

// File: rtl/i2cb_checker.sv
module i2cb_checker
    import i2cb_pkg::*;
#(
    parameter int          ADDR_W    = 16,
    parameter int          LOC_SHIFT = 12,
    parameter int          NUM_LOC   = 5,
    parameter logic [31:0] STS_WMASK = 32'h0C00_00EE
) (
    input logic              clk,
    input logic              rst_n,
    input logic              ev_valid,
    input logic              ev_ready,
    input logic              ev_done,
    input logic              bus_req,
    input logic              bus_we,
    input logic [ADDR_W-1:0] bus_addr,
    input logic [31:0]       bus_wdata,
    input logic [2:0]        bus_size,
    input logic              bus_done
);
    localparam logic [ADDR_W-1:0] LOW_MASK = ADDR_W'((1 << LOC_SHIFT) - 1);

    logic [ADDR_W-1:0] low_addr;
    assign low_addr = bus_addr & LOW_MASK;

    assert_req_held_R14: assert property (@(posedge clk) disable iff (!rst_n)
        bus_req && !bus_done |=> bus_req && $stable(bus_addr) && $stable(bus_wdata) && $stable(bus_we));

    assert_no_accept_R14: assert property (@(posedge clk) disable iff (!rst_n)
        bus_req |-> !ev_ready);

    assert_done_cause_R14: assert property (@(posedge clk) disable iff (!rst_n)
        ev_done |-> ($past(ev_valid && ev_ready) || $past(bus_req && bus_done)));

    assert_loc_range_R5: assert property (@(posedge clk) disable iff (!rst_n)
        bus_req |-> (bus_addr >> LOC_SHIFT) < ADDR_W'(NUM_LOC));

    assert_fifo_size_R3: assert property (@(posedge clk) disable iff (!rst_n)
        bus_req && low_addr == ADDR_W'(OFF_FIFO) |-> bus_size == 3'd1);

    assert_sts_mask_R7: assert property (@(posedge clk) disable iff (!rst_n)
        bus_req && bus_we && bus_size == 3'd4 && low_addr == ADDR_W'(OFF_STS)
        |-> (bus_wdata & ~STS_WMASK) == 32'h0);

endmodule

bind i2c_reg_bridge i2cb_checker #(
    .ADDR_W(ADDR_W), .LOC_SHIFT(LOC_SHIFT), .NUM_LOC(NUM_LOC), .STS_WMASK(STS_WMASK)
) u_chk (
    .clk(clk), .rst_n(rst_n), .ev_valid(ev_valid), .ev_ready(ev_ready), .ev_done(ev_done),
    .bus_req(bus_req), .bus_we(bus_we), .bus_addr(bus_addr), .bus_wdata(bus_wdata),
    .bus_size(bus_size), .bus_done(bus_done)
);

// File: tb/tb_i2c_reg_bridge.sv
module tb_i2c_reg_bridge;
    localparam int          CLK_PERIOD = 10;
    localparam logic [31:0] WMASK = 32'h0C00_00EE;
    localparam logic [31:0] IMASK = 32'h8000_0087;
    localparam logic [2:0]  K_SW = 3'd0, K_SR = 3'd1, K_WB = 3'd2, K_RB = 3'd3, K_SP = 3'd4;

    logic clk = 0, rst_n = 0;
    logic ev_valid = 0; logic [2:0] ev_kind = 0; logic [7:0] ev_wdata = 0;
    logic ev_ready, ev_done, ev_nak; logic [7:0] ev_rdata;
    logic bus_req, bus_we; logic [15:0] bus_addr; logic [31:0] bus_wdata; logic [2:0] bus_size;
    logic [31:0] bus_rdata = 0; logic bus_done = 0;

    int n_cmp = 0, n_bad = 0, wd = 0, lat = 1;
    int rd_count = 0, wr_count = 0, rd_seq = 0, busy_viol = 0;
    logic finished = 0;
    logic [31:0] last_rd_val = 0, last_wr_data = 0;
    logic [15:0] last_wr_addr = 0; logic [2:0] last_wr_size = 0;
    logic [7:0] got_rd; logic got_nak; logic [7:0] rd_bytes [8];

    always #(CLK_PERIOD/2) clk = ~clk;

    i2c_reg_bridge #(.STS_WMASK(WMASK), .INT_MASK(IMASK)) dut (.*);

    // Register-bus responder with a little latency
    always @(negedge clk) begin
        if (bus_done) bus_done = 0;
        else if (bus_req) begin
            if (lat == 0) begin
                bus_done = 1;
                if (bus_we) begin
                    wr_count++; last_wr_addr = bus_addr; last_wr_data = bus_wdata; last_wr_size = bus_size;
                end else begin
                    last_rd_val = ({bus_addr, 16'h0} ^ 32'h5A3C_96E1) + rd_seq * 32'h0103_0507;
                    bus_rdata = last_rd_val; rd_seq++; rd_count++;
                end
                lat = $urandom % 3;
            end else lat--;
        end
    end

    task automatic report();
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    endtask

    initial begin
        while (!finished && wd < 150000) begin @(posedge clk); wd++; end
        if (!finished) begin
            n_cmp++; n_bad++;
            $display("FAIL watchdog: actual %0d expected below 150000", wd);
            report();
        end
    end

    task automatic chk(input string rq, input logic [31:0] act, input logic [31:0] exp);
        n_cmp++;
        if (act !== exp) begin n_bad++; $display("FAIL %s: actual %h expected %h", rq, act, exp); end
    endtask

    function automatic logic [31:0] sts_wr(input logic [31:0] w, input int k);
        return w & (WMASK >> (8 * k));
    endfunction
    function automatic logic [31:0] sts_rd(input logic [31:0] r, input int k);
        return (r & 32'h03FF_FFFF) >> (8 * k);
    endfunction
    function automatic logic [15:0] addr_of(input int loc, input logic [11:0] off);
        return 16'(off) + 16'(loc << 12);
    endfunction
    function automatic logic [31:0] rd_word();
        return {rd_bytes[3], rd_bytes[2], rd_bytes[1], rd_bytes[0]};
    endfunction

    task automatic do_ev(input logic [2:0] k, input logic [7:0] d);
        @(negedge clk);
        while (!ev_ready) @(negedge clk);
        ev_valid = 1; ev_kind = k; ev_wdata = d;
        @(negedge clk);
        ev_valid = 0;
        while (!ev_done) begin
            if (bus_req && ev_ready) busy_viol++;
            @(negedge clk);
        end
        got_rd = ev_rdata; got_nak = ev_nak;
    endtask

    task automatic wr_reg(input logic [7:0] idx, input int n, input logic [31:0] w);
        do_ev(K_SW, 0); do_ev(K_WB, idx);
        for (int i = 0; i < n; i++) do_ev(K_WB, w[8*i +: 8]);
        do_ev(K_SP, 0);
    endtask

    task automatic rd_reg(input logic [7:0] idx, input int n);
        do_ev(K_SW, 0); do_ev(K_WB, idx); do_ev(K_SR, 0);
        for (int i = 0; i < n; i++) begin do_ev(K_RB, 0); rd_bytes[i] = got_rd; end
        do_ev(K_SP, 0);
    endtask

    initial begin
        int w0, r0, loc;
        logic [31:0] w, exp_w;
        process::self().srandom(32'd1234);
        repeat (3) @(negedge clk);
        chk("R13 reset ready", 32'(ev_ready), 1);
        chk("R13 reset req", 32'(bus_req), 0);
        chk("R13 reset done", 32'(ev_done), 0);
        rst_n = 1;
        rd_reg(8'h00, 1); chk("R13 reset locality", 32'(rd_bytes[0]), 0);
        rd_reg(8'h40, 1); chk("R13 reset checksum enable", 32'(rd_bytes[0]), 0);

        // R1 index decode
        do_ev(K_SW, 0); do_ev(K_WB, 8'h38); chk("R1 device-address NAK", 32'(got_nak), 1);
        do_ev(K_SW, 0); do_ev(K_WB, 8'h10); chk("R1 unmapped NAK", 32'(got_nak), 1);
        do_ev(K_SW, 0); do_ev(K_WB, 8'h4C); chk("R1 mapped ACK", 32'(got_nak), 0);
        do_ev(K_SP, 0);

        // R2/R4 buffered write, fifth data byte NAKed, commit at stop
        w0 = wr_count;
        do_ev(K_SW, 0); do_ev(K_WB, 8'h04);
        do_ev(K_WB, 8'h11); do_ev(K_WB, 8'h22); do_ev(K_WB, 8'h33); do_ev(K_WB, 8'h44);
        chk("R2 fourth data byte ACK", 32'(got_nak), 0);
        do_ev(K_WB, 8'h55); chk("R2 fifth data byte NAK", 32'(got_nak), 1);
        chk("R4 nothing before stop", wr_count, w0);
        do_ev(K_SP, 0);
        chk("R4 one write at stop", wr_count, w0 + 1);
        chk("R4 little-endian data", last_wr_data, 32'h4433_2211);
        chk("R4 address", 32'(last_wr_addr), 32'(addr_of(0, 12'h000)));
        chk("R4 size", 32'(last_wr_size), 4);
        wr_reg(8'h48, 2, 32'h0000_BEEF);
        chk("R4 partial word zero filled", last_wr_data, 32'h0000_BEEF);

        // R3 FIFO writes forwarded immediately
        do_ev(K_SW, 0); do_ev(K_WB, 8'h24);
        for (int i = 0; i < 7; i++) begin
            w0 = wr_count;
            do_ev(K_WB, 8'(8'hA0 + i));
            chk("R3 fifo byte ACK", 32'(got_nak), 0);
            chk("R3 fifo byte forwarded", wr_count, w0 + 1);
            chk("R3 fifo data", last_wr_data, 32'(8'hA0 + i));
            chk("R3 fifo size", 32'(last_wr_size), 1);
        end
        chk("R3 fifo address", 32'(last_wr_addr), 32'h024);
        w0 = wr_count; do_ev(K_SP, 0); chk("R3 no write at stop", wr_count, w0);

        // R5 locality
        w0 = wr_count;
        wr_reg(8'h00, 1, 32'd3);
        chk("R5 locality write is local", wr_count, w0);
        rd_reg(8'h00, 1); chk("R5 locality readback", 32'(rd_bytes[0]), 3);
        wr_reg(8'h00, 1, 32'd7);
        rd_reg(8'h00, 1); chk("R5 invalid locality ignored", 32'(rd_bytes[0]), 3);
        wr_reg(8'h04, 4, 32'h0102_0304);
        chk("R5 address carries locality", 32'(last_wr_addr), 32'(addr_of(3, 12'h000)));
        wr_reg(8'h00, 1, 32'd0);

        // R6 checksum enable
        w0 = wr_count;
        wr_reg(8'h40, 1, 32'hFF);
        chk("R6 no bus write", wr_count, w0);
        rd_reg(8'h40, 2); chk("R6 only bit0 kept", rd_word() & 32'hFFFF, 1);
        wr_reg(8'h40, 1, 32'hFE);
        rd_reg(8'h40, 1); chk("R6 cleared by even value", 32'(rd_bytes[0]), 0);

        // R12 interrupt enable mask
        wr_reg(8'h08, 4, 32'hFFFF_FFFF);
        chk("R12 masked data", last_wr_data, IMASK);
        chk("R12 address", 32'(last_wr_addr), 32'h008);

        // R10 interrupt capability
        r0 = rd_count; w0 = wr_count;
        rd_reg(8'h14, 4); chk("R10 capability value", rd_word(), IMASK);
        chk("R10 no bus read", rd_count, r0);
        wr_reg(8'h14, 4, 32'h1234_5678); chk("R10 write dropped", wr_count, w0);

        // R8 cached read
        r0 = rd_count;
        rd_reg(8'h48, 6);
        chk("R8 single fetch", rd_count, r0 + 1);
        chk("R8 cached bytes", rd_word(), last_rd_val);
        chk("R8 past cache byte4", 32'(rd_bytes[4]), 0);
        chk("R8 past cache byte5", 32'(rd_bytes[5]), 0);

        // R9 status reads
        rd_reg(8'h18, 4); chk("R9 status base read", rd_word(), sts_rd(last_rd_val, 0));
        rd_reg(8'h19, 3);
        chk("R9 status offset1 read", {8'h00, rd_bytes[2], rd_bytes[1], rd_bytes[0]}, sts_rd(last_rd_val, 1));
        rd_reg(8'h1B, 1); chk("R9 status offset3 read", 32'(rd_bytes[0]), sts_rd(last_rd_val, 3));

        // R11 FIFO reads
        r0 = rd_count;
        do_ev(K_SW, 0); do_ev(K_WB, 8'h24); do_ev(K_SR, 0);
        for (int i = 0; i < 3; i++) begin
            do_ev(K_RB, 0);
            chk("R11 fresh bus read", rd_count, r0 + i + 1);
            chk("R11 fifo byte", 32'(got_rd), 32'(last_rd_val[7:0]));
        end
        do_ev(K_SP, 0);

        // R13 clearing
        w0 = wr_count;
        do_ev(K_SW, 0); do_ev(K_WB, 8'h04); do_ev(K_WB, 8'h12); do_ev(K_WB, 8'h34);
        do_ev(K_SW, 0); do_ev(K_SP, 0);
        chk("R13 start-write discards buffer", wr_count, w0);
        rd_reg(8'h14, 1);
        r0 = rd_count;
        do_ev(K_SR, 0);
        for (int i = 0; i < 4; i++) begin
            do_ev(K_RB, 0);
            chk("R13 stop after read clears cache", 32'(got_rd), 0);
        end
        do_ev(K_SP, 0);
        chk("R13 no bus read after clear", rd_count, r0);

        // R7 directed status writes, then random mix (R4 R5 R7 R12)
        wr_reg(8'h18, 4, 32'hFFFF_FFFF);
        chk("R7 base data", last_wr_data, sts_wr(32'hFFFF_FFFF, 0));
        chk("R7 base size", 32'(last_wr_size), 4);
        wr_reg(8'h1A, 1, 32'h0000_00FF);
        chk("R7 offset2 address", 32'(last_wr_addr), 32'h01A);
        chk("R7 offset2 size", 32'(last_wr_size), 1);
        chk("R7 offset2 data", last_wr_data, sts_wr(32'h0000_00FF, 2));
        for (int i = 0; i < 30; i++) begin
            int pick, k;
            logic [7:0] ix; logic [11:0] off; logic [2:0] sz;
            loc = $urandom % 5; pick = $urandom % 4; k = $urandom % 4; w = $urandom;
            wr_reg(8'h00, 1, 32'(loc));
            sz = 4; exp_w = w;
            unique case (pick)
                0: begin ix = 8'h04; off = 12'h000; end
                1: begin ix = 8'h08; off = 12'h008; exp_w = w & IMASK; end
                2: begin ix = 8'(8'h18 + k); off = 12'(12'h018 + k); exp_w = sts_wr(w, k);
                         if (k != 0) sz = 1; end
                default: begin ix = 8'h4C; off = 12'hF04; end
            endcase
            w0 = wr_count;
            wr_reg(ix, 4, w);
            chk("R4 random commit count", wr_count, w0 + 1);
            chk("R5 random address", 32'(last_wr_addr), 32'(addr_of(loc, off)));
            chk("R7 random data", last_wr_data, exp_w);
            chk("R7 random size", 32'(last_wr_size), 32'(sz));
        end
        chk("R14 ready low while bus pending", busy_viol, 0);
        finished = 1;
        report();
    end
endmodule